// File: doc/BRIEF.md
# Burst Job Sequencer for a 32-bit Bus-Master Engine

This block sits between a local agent that queues transfer jobs and a 32-bit bus-master engine that runs the bus protocol. A job gives a start address, a 4-bit bus command, active-low byte enables and a beat count. The block turns the job into a request to the engine: request, ready, last, address, command, byte enables and write data. It then follows the per-phase status code that the engine reports.

Write words are fetched from the local side by beat index. Read words are handed back with their beat index when a phase completes. The block moves its beat pointer only on a completing status. When the engine reports a retry, the block releases the request for one cycle and reissues the transaction from the first beat that did not complete. When all beats are done, or the job ends in an error, the block signals completion with a result code. It then waits for the next job.

Top module: `busmaster_job_sequencer`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `m_req` and `done` are low and `cmd_ready` is high.
- R2: A job accepted on `cmd_valid` while `cmd_ready` is high raises `m_req` and `m_rdy` in the next cycle. For as long as `m_req` stays high, `m_addr`, `m_cmd` and `m_be_n` hold the job's values and do not change. Bit 0 of the command set to 1 marks a write.
- R3: `m_last` is high exactly when the beat being offered is the job's final beat. For a one-beat job, it rises together with `m_req` and `m_rdy`.
- R4: A status of 0 (wait) or 2 (disconnect without data) completes nothing. The beat index `wr_idx`, `m_addr` and `m_last` are unchanged in the next cycle.
- R5: A status of 1 (transferred) or 3 (disconnect with data) completes the beat. On a write, the next cycle presents the next word, whose index is shown on `wr_idx`, on `m_wdata`.
- R6: On a read, the cycle after a completing status pulses `rd_we`. It carries the completed beat's index on `rd_idx` and the `m_rdata` value that was sampled on `rd_word`.
- R7: A completing status on the final beat drops `m_req` in the next cycle. In that same cycle it pulses `done` with code 0 (success) and raises `cmd_ready`.
- R8: Status 4 (target abort) drops `m_req` in the next cycle and pulses `done` with code 1. The transaction is not issued again.
- R9: Status 5 (master abort) drops `m_req` in the next cycle and pulses `done` with code 2, without any retry.
- R10: Status 6 (retry) drops `m_req` for exactly one cycle. The request is then raised again with `m_addr` equal to the start address plus 4 times the number of completed beats, and the beats resume from the first one that did not complete.
- R11: After MAX_REISSUE reissues (8 by default), a further retry ends the job with `done` code 3 (timeout) instead of reissuing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Job offered |
| cmd_ready | output | 1 | Block is idle and takes a job |
| cmd_addr | input | ADDR_W | Job start address |
| cmd_bus | input | 4 | Bus command, bit 0 set for write |
| cmd_be_n | input | 4 | Active-low byte enables |
| cmd_beats | input | CNT_W | Beat count, 1 or more |
| wr_idx | output | CNT_W | Index of the write word wanted |
| wr_word | input | DATA_W | Write word for `wr_idx` |
| rd_we | output | 1 | Read word valid |
| rd_idx | output | CNT_W | Beat index of the read word |
| rd_word | output | DATA_W | Captured read word |
| done | output | 1 | Job finished pulse |
| done_code | output | 2 | 0 success, 1 target abort, 2 master abort, 3 timeout |
| m_req | output | 1 | Transaction request to the engine |
| m_rdy | output | 1 | Data ready / read sink ready |
| m_last | output | 1 | Final beat marker |
| m_addr | output | ADDR_W | Transaction address |
| m_cmd | output | 4 | Bus command |
| m_be_n | output | 4 | Byte enables, active low |
| m_wdata | output | DATA_W | Write data |
| m_status | input | 3 | Per-phase status code from the engine |
| m_rdata | input | DATA_W | Read data from the engine |

## Verification
On a read, the capture of the final beat and the completion pulse fall in the same cycle. Both are caused by the same completing status on the last beat. Read bursts of several lengths are run, with plain, wait-padded and disconnect-with-data completions. In the cycle after the final phase, the bench checks the index and value of the captured word first, and only then reads the `done` pulse and its code. A reissue that follows a retry is judged by the length of the gap, by the restart address, and by the next beat index offered.

// File: rtl/seq_pkg.sv
// Package: shared constants and types for the burst job sequencer.
// Assumes a 3-bit per-phase status code and a 2-bit job result code.
package seq_pkg;
    localparam logic [2:0] ST_WAIT    = 3'd0;
    localparam logic [2:0] ST_XFER    = 3'd1;
    localparam logic [2:0] ST_DISC_ND = 3'd2;
    localparam logic [2:0] ST_DISC_D  = 3'd3;
    localparam logic [2:0] ST_TABORT  = 3'd4;
    localparam logic [2:0] ST_MABORT  = 3'd5;
    localparam logic [2:0] ST_RETRY   = 3'd6;

    localparam logic [1:0] RES_OK      = 2'd0;
    localparam logic [1:0] RES_TABORT  = 2'd1;
    localparam logic [1:0] RES_MABORT  = 2'd2;
    localparam logic [1:0] RES_TIMEOUT = 2'd3;

    typedef enum logic [2:0] {
        PH_HOLD,
        PH_BEAT,
        PH_TABORT,
        PH_MABORT,
        PH_RETRY
    } phase_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BUSY,
        S_GAP
    } seq_state_e;
endpackage

// File: rtl/seq_status_decode.sv
// Module: seq_status_decode
// Folds the 3-bit per-phase status into the five actions that the
// sequencer distinguishes. Assumes code 7 is never sent; it is held as a wait.
module seq_status_decode
    import seq_pkg::*;
(
    input  logic [2:0] status,
    output phase_e     phase
);
    // Map each status code to its action class.
    always_comb begin
        unique case (status)
            ST_XFER, ST_DISC_D: phase = PH_BEAT;
            ST_TABORT:          phase = PH_TABORT;
            ST_MABORT:          phase = PH_MABORT;
            ST_RETRY:           phase = PH_RETRY;
            default:            phase = PH_HOLD;
        endcase
    end
endmodule

// File: rtl/seq_beat_ctrl.sv
// Module: seq_beat_ctrl
// Holds the job's base address and length, the current beat pointer and the
// beat at which the current issue started. It derives the issue address from
// them. Assumes one 32-bit word per beat, so addresses step by 4.
module seq_beat_ctrl #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic              reissue,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CNT_W-1:0]  total_in,
    output logic [CNT_W-1:0]  beat,
    output logic              is_last,
    output logic [ADDR_W-1:0] issue_addr
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  issue_beat_q;

    // Load the job, step the beat pointer, and mark the restart point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q       <= '0;
            total_q      <= ONE;
            beat         <= '0;
            issue_beat_q <= '0;
        end else if (start) begin
            base_q       <= base_in;
            total_q      <= (total_in == '0) ? ONE : total_in;
            beat         <= '0;
            issue_beat_q <= '0;
        end else begin
            if (advance) beat <= beat + ONE;
            if (reissue) issue_beat_q <= beat;
        end
    end

    // Flag the final beat and form the address of the current issue.
    always_comb begin
        is_last    = (beat == total_q - ONE);
        issue_addr = base_q + ADDR_W'({issue_beat_q, 2'b00});
    end
endmodule

// File: rtl/seq_retry_budget.sv
// Module: seq_retry_budget
// Counts reissues within one job. It reports when the budget is used up.
// Assumes clear and bump are never high in the same cycle.
module seq_retry_budget #(
    parameter int MAX_REISSUE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic exhausted
);
    localparam int RW = $clog2(MAX_REISSUE + 1);
    localparam logic [RW-1:0] LIMIT = RW'(MAX_REISSUE);

    logic [RW-1:0] used_q;

    // Reset per job, count each reissue granted.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) used_q <= '0;
        else if (bump)       used_q <= used_q + RW'(1);
    end

    // The budget is spent once the count reaches the limit.
    assign exhausted = (used_q == LIMIT);
endmodule

// File: rtl/seq_read_capture.sv
// Module: seq_read_capture
// Registers a completed read beat, with its index, toward the local store.
// Assumes the local store accepts one word per cycle without back-pressure.
module seq_read_capture #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CNT_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              we,
    output logic [CNT_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    // Latch the bus word on the completing edge and pulse the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we   <= 1'b0;
            idx  <= '0;
            word <= '0;
        end else begin
            we <= capture;
            if (capture) begin
                idx  <= idx_in;
                word <= data_in;
            end
        end
    end
endmodule

// File: rtl/busmaster_job_sequencer.sv
// Module: busmaster_job_sequencer (top)
// Takes one job at a time and requests it from a bus-master engine.
// It steps through the beats on completing statuses, reissues after a retry
// from the first beat that did not complete, and reports a result code.
// Assumes the local side supplies write words with no delay from wr_idx.
module busmaster_job_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int MAX_REISSUE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [3:0]        cmd_bus,
    input  logic [3:0]        cmd_be_n,
    input  logic [CNT_W-1:0]  cmd_beats,
    output logic [CNT_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_word,
    output logic              rd_we,
    output logic [CNT_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic              done,
    output logic [1:0]        done_code,
    output logic              m_req,
    output logic              m_rdy,
    output logic              m_last,
    output logic [ADDR_W-1:0] m_addr,
    output logic [3:0]        m_cmd,
    output logic [3:0]        m_be_n,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [2:0]        m_status,
    input  logic [DATA_W-1:0] m_rdata
);
    seq_state_e       state_q;
    phase_e           phase;
    logic [3:0]       cmd_q;
    logic [3:0]       be_n_q;
    logic             busy, start, advance, reissue, bump, capture;
    logic             exhausted, is_last;
    logic [CNT_W-1:0] beat;

    seq_status_decode u_decode (
        .status (m_status),
        .phase  (phase)
    );

    seq_beat_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .advance    (advance),
        .reissue    (reissue),
        .base_in    (cmd_addr),
        .total_in   (cmd_beats),
        .beat       (beat),
        .is_last    (is_last),
        .issue_addr (m_addr)
    );

    seq_retry_budget #(.MAX_REISSUE(MAX_REISSUE)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .bump      (bump),
        .exhausted (exhausted)
    );

    seq_read_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .idx_in  (beat),
        .data_in (m_rdata),
        .we      (rd_we),
        .idx     (rd_idx),
        .word    (rd_word)
    );

    // Derive the per-cycle control strobes from the state and the phase action.
    always_comb begin
        busy    = (state_q == S_BUSY);
        start   = (state_q == S_IDLE) && cmd_valid;
        advance = busy && (phase == PH_BEAT);
        reissue = (state_q == S_GAP);
        bump    = busy && (phase == PH_RETRY) && !exhausted;
        capture = advance && !cmd_q[0];
    end

    // Sequence idle, request and release gap; raise the result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cmd_q     <= '0;
            be_n_q    <= '1;
            done      <= 1'b0;
            done_code <= RES_OK;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (cmd_valid) begin
                    state_q <= S_BUSY;
                    cmd_q   <= cmd_bus;
                    be_n_q  <= cmd_be_n;
                end
                S_BUSY: unique case (phase)
                    PH_BEAT: if (is_last) begin
                        state_q   <= S_IDLE;
                        done      <= 1'b1;
                        done_code <= RES_OK;
                    end
                    PH_TABORT: begin
                        state_q   <= S_IDLE;
                        done      <= 1'b1;
                        done_code <= RES_TABORT;
                    end
                    PH_MABORT: begin
                        state_q   <= S_IDLE;
                        done      <= 1'b1;
                        done_code <= RES_MABORT;
                    end
                    PH_RETRY: if (exhausted) begin
                        state_q   <= S_IDLE;
                        done      <= 1'b1;
                        done_code <= RES_TIMEOUT;
                    end else begin
                        state_q <= S_GAP;
                    end
                    default: ;
                endcase
                S_GAP:   state_q <= S_BUSY;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the engine-facing and local-facing outputs.
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        m_req     = busy;
        m_rdy     = busy;
        m_last    = busy && is_last;
        m_cmd     = cmd_q;
        m_be_n    = be_n_q;
        wr_idx    = beat;
        m_wdata   = wr_word;
    end
endmodule

// File: rtl/seq_checker.sv
// Module: seq_checker
// Protocol properties of the job sequencer, bound to its top module.
// Assumes it observes the top-level ports only.
module seq_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              done,
    input logic [1:0]        done_code,
    input logic              m_req,
    input logic              m_rdy,
    input logic              m_last,
    input logic [ADDR_W-1:0] m_addr,
    input logic [3:0]        m_cmd,
    input logic [3:0]        m_be_n,
    input logic [2:0]        m_status,
    input logic [CNT_W-1:0]  wr_idx
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!m_req && !done && cmd_ready));

    p_fields_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && $past(m_req)) |-> ($stable(m_addr) && $stable(m_cmd) && $stable(m_be_n)));

    p_last_in_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> (m_req && m_rdy));

    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && (m_status == 3'd0 || m_status == 3'd2)) |=>
        (m_req && $stable(wr_idx) && $stable(m_addr) && $stable(m_last)));

    p_done_is_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!m_req && cmd_ready));

    p_tabort_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_status == 3'd4) |=> (!m_req && done && done_code == 2'd1));

    p_mabort_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_status == 3'd5) |=> (!m_req && done && done_code == 2'd2));

    p_retry_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_status == 3'd6) |=> !m_req);
endmodule

bind busmaster_job_sequencer seq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .done      (done),
    .done_code (done_code),
    .m_req     (m_req),
    .m_rdy     (m_rdy),
    .m_last    (m_last),
    .m_addr    (m_addr),
    .m_cmd     (m_cmd),
    .m_be_n    (m_be_n),
    .m_status  (m_status),
    .wr_idx    (wr_idx)
);

// File: tb/busmaster_job_sequencer_tb.sv
`timescale 1ns/1ps
module busmaster_job_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [3:0]  cmd_bus = '0;
    logic [3:0]  cmd_be_n = '1;
    logic [7:0]  cmd_beats = 8'd1;
    logic [7:0]  wr_idx;
    logic [31:0] wr_word;
    logic        rd_we;
    logic [7:0]  rd_idx;
    logic [31:0] rd_word;
    logic        done;
    logic [1:0]  done_code;
    logic        m_req, m_rdy, m_last;
    logic [31:0] m_addr;
    logic [3:0]  m_cmd, m_be_n;
    logic [31:0] m_wdata;
    logic [2:0]  m_status = 3'd0;
    logic [31:0] m_rdata = '0;
    logic [7:0]  job_id = 8'd0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // Local write store: the word for an index is a fixed function of job and index.
    assign wr_word = {8'hC5, job_id, 8'h00, wr_idx};

    busmaster_job_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_bus(cmd_bus), .cmd_be_n(cmd_be_n), .cmd_beats(cmd_beats),
        .wr_idx(wr_idx), .wr_word(wr_word), .rd_we(rd_we), .rd_idx(rd_idx), .rd_word(rd_word),
        .done(done), .done_code(done_code), .m_req(m_req), .m_rdy(m_rdy), .m_last(m_last),
        .m_addr(m_addr), .m_cmd(m_cmd), .m_be_n(m_be_n), .m_wdata(m_wdata),
        .m_status(m_status), .m_rdata(m_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scripted engine: status for this phase by mode, request-cycle count, beat and retries so far.
    function automatic logic [2:0] pick(input int mode, input int cyc, input int beat, input int retr);
        case (mode)
            0: return 3'd1;
            1: return (cyc % 2 == 0) ? 3'd0 : 3'd1;
            2: return (cyc % 3 == 0) ? 3'd2 : 3'd3;
            3: return (beat == 2 && retr == 0) ? 3'd6 : 3'd1;
            4: return (beat == 1) ? 3'd4 : 3'd1;
            5: return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    // Run one job against the scripted engine and judge every cycle.
    task automatic run_job(input logic [31:0] a, input int n, input bit wr, input int mode,
                           input logic [1:0] exp_code, output int beats_done, output int rises);
        int beat = 0, cyc = 0, retr = 0, gap = 0;
        bit prev_req = 0, prev_hold = 0, pend = 0, finished = 0;
        logic [7:0]  pend_idx = '0, prev_idx = '0;
        logic [31:0] pend_word = '0, prev_addr = '0;
        logic [2:0]  st;
        logic [3:0]  bus = wr ? 4'b0111 : 4'b0110;
        logic [3:0]  be = ~(4'(n) ^ 4'h5);
        rises = 0;
        job_id = job_id + 8'd1;
        check(cmd_ready == 1'b1, "R7 idle before job", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_addr = a; cmd_bus = bus; cmd_be_n = be; cmd_beats = 8'(n);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(m_req && m_rdy, "R2 request after accept", {m_req, m_rdy}, 64'd3);
        for (int it = 0; it < 400; it++) begin
            if (pend) begin
                // R6: captured read beat one cycle after its completing phase
                check(rd_we && rd_idx == pend_idx && rd_word == pend_word, "R6 read capture",
                      {rd_we, rd_idx, rd_word}, {1'b1, pend_idx, pend_word});
                pend = 0;
            end
            if (done) begin finished = 1; break; end
            if (m_req) begin
                if (!prev_req) begin
                    rises++;
                    if (rises > 1) check(gap == 1, "R10 one-cycle release", 64'(gap), 64'd1);
                    check(m_addr == a + 32'(4 * beat), "R10 issue address", 64'(m_addr), 64'(a + 32'(4 * beat)));
                    gap = 0;
                end else begin
                    check(m_addr == prev_addr, "R2 address steady", 64'(m_addr), 64'(prev_addr));
                end
                check(m_cmd == bus && m_be_n == be, "R2 command and enables", {m_cmd, m_be_n}, {bus, be});
                check(m_last == (beat == n - 1), "R3 last marker", 64'(m_last), 64'(beat == n - 1));
                check(wr_idx == 8'(beat), "R5 beat index", 64'(wr_idx), 64'(beat));
                if (wr) check(m_wdata == {8'hC5, job_id, 8'h00, 8'(beat)}, "R5 write word",
                              64'(m_wdata), 64'({8'hC5, job_id, 8'h00, 8'(beat)}));
                if (prev_hold)
                    check(wr_idx == prev_idx, "R4 held after wait", 64'(wr_idx), 64'(prev_idx));
                st = pick(mode, cyc, beat, retr);
                m_status = st;
                m_rdata  = {8'h5A, job_id, 8'h11, 8'(beat)};
                prev_hold = (st == 3'd0 || st == 3'd2);
                prev_idx  = wr_idx;
                prev_addr = m_addr;
                if (st == 3'd1 || st == 3'd3) begin
                    if (!wr) begin pend = 1; pend_idx = 8'(beat); pend_word = m_rdata; end
                    beat++;
                end
                if (st == 3'd6) retr++;
                cyc++;
            end else begin
                gap++;
                prev_hold = 0;
                m_status = 3'd0;
            end
            prev_req = m_req;
            @(negedge clk);
        end
        m_status = 3'd0;
        check(finished, "R7 job completes", 64'(finished), 64'd1);
        check(done_code == exp_code, "R7 result code", 64'(done_code), 64'(exp_code));
        check(!m_req && cmd_ready, "R7 idle with done", {m_req, cmd_ready}, 64'd1);
        beats_done = beat;
        @(negedge clk);
    endtask

    // Vector table: {start address, beat count, write flag, engine mode}; all end in success.
    localparam int NV = 7;
    localparam logic [43:0] VEC [NV] = '{
        {32'h1000_0000, 8'd1, 1'b1, 3'd0},
        {32'h1000_0100, 8'd4, 1'b1, 3'd1},
        {32'h2000_0040, 8'd5, 1'b0, 3'd0},
        {32'h2000_0800, 8'd6, 1'b0, 3'd2},
        {32'h3000_0000, 8'd5, 1'b1, 3'd3},
        {32'h3000_1000, 8'd4, 1'b0, 3'd3},
        {32'h4000_0000, 8'd1, 1'b0, 3'd1}
    };

    initial begin
        int nb, rs;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!m_req && !done && cmd_ready && !rd_we, "R1 reset state",
              {m_req, done, cmd_ready, rd_we}, 64'b0010);
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_req && !done && cmd_ready, "R1 after release", {m_req, done, cmd_ready}, 64'b001);

        // Table walk: single and burst, write and read, waits, disconnects, one retry.
        for (int i = 0; i < NV; i++) begin
            run_job(VEC[i][43:12], int'(VEC[i][11:4]), VEC[i][3], int'(VEC[i][2:0]), 2'd0, nb, rs);
            check(nb == int'(VEC[i][11:4]), "R5 all beats completed", 64'(nb), 64'(VEC[i][11:4]));
            if (VEC[i][2:0] == 3'd3)
                check(rs == 2, "R10 reissued once", 64'(rs), 64'd2);
        end

        // R8: target abort on beat 1 of a write; never reissued.
        run_job(32'h5000_0000, 4, 1'b1, 4, 2'd1, nb, rs);
        check(nb == 1 && rs == 1, "R8 abort after one beat", {32'(nb), 32'(rs)}, {32'd1, 32'd1});
        for (int k = 0; k < 20; k++) begin
            check(!m_req, "R8 no request after abort", 64'(m_req), 64'd0);
            @(negedge clk);
        end

        // R9: master abort on a read; no retry, no data.
        run_job(32'h6000_0000, 3, 1'b0, 5, 2'd2, nb, rs);
        check(nb == 0 && rs == 1, "R9 no retry after master abort", {32'(nb), 32'(rs)}, {32'd0, 32'd1});
        check(!rd_we, "R9 no read word", 64'(rd_we), 64'd0);

        // R11: endless retry gives 1 issue plus 8 reissues, then timeout.
        run_job(32'h7000_0000, 2, 1'b1, 6, 2'd3, nb, rs);
        check(rs == 9, "R11 reissue budget", 64'(rs), 64'd9);

        // Back-to-back job after the timeout still succeeds.
        run_job(32'h7000_0200, 2, 1'b0, 0, 2'd0, nb, rs);
        check(nb == 2, "R7 job after timeout", 64'(nb), 64'd2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule